// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns internal transfer requests into bus cycles on a pin-saving external bus. Sixteen shared lines carry the address first and then the data. Four upper lines carry the top address bits first and then a status code. A single-cycle address strobe tells external logic when to latch the address. After that come active-low read or write strobes, a data-buffer enable and a direction line. A not-ready input stretches the data phase. A hold input lets another master take the bus.

A requester presents one transfer at a time and holds it stable until `done` pulses. Each transfer has a 20-bit byte address, a memory or I/O select, a byte or word size, write data, a two-bit segment tag and an interrupt-enable bit. Every cycle has four base clock periods, plus any wait states. A word at an odd address is carried as two byte cycles, lowest byte first. Read data is returned in little-endian order. Three-state pins are modelled as value outputs with separate enable outputs.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After synchronous reset the block is idle: `ale`=0, `rd_n`=`wr_n`=`den_n`=1, `hlda`=0, `ad_oe`=`ah_oe`=0, `done`=0.
- R2: An idle request with `hold` low starts a cycle on the next clock. For that one cycle `ale`=1, `ad_out`/`ah_out` carry address bits 15:0 and 19:16, and `ad_oe`=`ah_oe`=1. `ale` is never high two cycles in a row.
- R3: In every clock after the address cycle of a bus cycle, `ah_out` is {0, interrupt-enable, seg[1:0]} and `bhe_n`=1. The seg codes are 00 extra, 01 stack, 10 code or none, 11 data.
- R4: A read holds `rd_n` and `den_n` low from the second clock up to the last clock that samples ready. During a read `ad_oe`=0 and `dtr`=0. The data is captured when ready is seen, and `done` is high in the following clock with `rd_data` valid and both strobes high.
- R5: A write holds `wr_n` low for the same window. `dtr`=1 for the whole cycle, and `ad_oe`=1 with write data on `ad_out` from the second clock to the end of the cycle.
- R6: `ready` is sampled at the end of the third clock and of every wait clock. Each low sample adds one wait clock, so a strobe lasts 2 + (number of low samples) clocks and the cycle lasts 4 + that number.
- R7: `bhe_n` is low during the address cycle exactly when the upper lane (`ad_out[15:8]`) takes part. An aligned word uses both lanes. A byte uses the lower lane at an even address and the upper lane at an odd one, with the byte driven on both lanes. A byte read returns {8'h00, lane}.
- R8: A word at an odd address A runs as two cycles with a single `done`. The first cycle goes to A on the upper lane and carries the low byte. The second goes to A+1 (modulo 2^20) on the lower lane and carries the high byte.
- R9: `hold` is honoured only while idle, never inside a transfer, and it wins over a pending request. `hlda` rises the clock after and, while it is high, `ad_oe`, `ah_oe` and `ctl_oe` are 0. Dropping `hold` returns the block to idle on the next clock.
- R10: `rd_n` and `wr_n` are never low together, and neither is low while `ale` is high.
- R11: `mio` equals the request's memory select (1 memory, 0 I/O) throughout the bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request, held until `done` |
| req_write | input | 1 | 1 write, 0 read |
| req_mem | input | 1 | 1 memory, 0 I/O |
| req_word | input | 1 | 1 word, 0 byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_seg | input | 2 | Segment tag shown in status |
| req_ie | input | 1 | Interrupt-enable flag shown in status |
| done | output | 1 | One-clock end-of-transfer pulse |
| rd_data | output | 16 | Read result, valid with `done` |
| ready | input | 1 | Slave ready; low inserts waits |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted, outputs floated |
| ad_in | input | 16 | Shared lines as seen from outside |
| ad_out | output | 16 | Shared lines driven value |
| ad_oe | output | 1 | Shared lines enable |
| ah_out | output | 4 | Upper address / status lines |
| ah_oe | output | 1 | Upper lines enable |
| bhe_n | output | 1 | Upper-lane enable, then status bit 7 |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| mio | output | 1 | Memory (1) or I/O (0) cycle |
| dtr | output | 1 | Buffer direction, 1 transmit |
| den_n | output | 1 | Data buffer enable, active low |
| ctl_oe | output | 1 | Control line enable |

## Verification
The bound checker watches the pin-level invariants on every clock. These are the one-clock address strobe, strobe exclusivity, the fixed status bits after the address phase, a strobe kept alive while ready is low, the buffer enable during strobes, and full float with a hold grant only after a hold request. Only the bench scenarios can show the arithmetic content: the exact addresses and lane enables, the split order for odd words and its wrap at the top of the space, the captured read data, the strobe length as a function of the wait count, and the refusal of hold mid-transfer.

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_mem,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_seg,
  input  logic          req_ie,
  output logic          done,
  output logic [DW-1:0] rd_data,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] ah_out,
  output logic          ah_oe,
  output logic          bhe_n,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          mio,
  output logic          dtr,
  output logic          den_n,
  output logic          ctl_oe
);
  localparam int HW = AW - DW;
  localparam int BW = DW / 2;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4, S_HOLD} st_t;
  st_t st;

  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q, rd_q;
  logic [1:0]    seg_q;
  logic          wr_q, mem_q, word_q, ie_q, split_q, part_q;

  logic aligned, upper_en, strobe, active, more;
  logic [BW-1:0] wb, lane_in;
  logic [DW-1:0] drive_data;

  assign aligned    = word_q & ~split_q;
  assign upper_en   = aligned | (~aligned & a_q[0]);
  assign wb         = (split_q & part_q) ? wd_q[DW-1:BW] : wd_q[BW-1:0];
  assign drive_data = aligned ? wd_q : {wb, wb};
  assign lane_in    = a_q[0] ? ad_in[DW-1:BW] : ad_in[BW-1:0];
  assign more       = split_q & ~part_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      a_q     <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      seg_q   <= '0;
      wr_q    <= 1'b0;
      mem_q   <= 1'b0;
      word_q  <= 1'b0;
      ie_q    <= 1'b0;
      split_q <= 1'b0;
      part_q  <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (hold) st <= S_HOLD;
          else if (req_valid) begin
            st      <= S_T1;
            a_q     <= req_addr;
            wd_q    <= req_wdata;
            seg_q   <= req_seg;
            wr_q    <= req_write;
            mem_q   <= req_mem;
            word_q  <= req_word;
            ie_q    <= req_ie;
            split_q <= req_word & req_addr[0];
            part_q  <= 1'b0;
          end
        end
        S_T1: st <= S_T2;
        S_T2: st <= S_T3;
        S_T3, S_TW: begin
          if (ready) begin
            st <= S_T4;
            if (!wr_q) begin
              if (aligned) rd_q <= ad_in;
              else if (!word_q) rd_q <= {{BW{1'b0}}, lane_in};
              else if (!part_q) rd_q[BW-1:0] <= lane_in;
              else rd_q[DW-1:BW] <= lane_in;
            end
          end else st <= S_TW;
        end
        S_T4: begin
          if (more) begin
            st     <= S_T1;
            part_q <= 1'b1;
            a_q    <= a_q + AW'(1);
          end else st <= S_IDLE;
        end
        S_HOLD: if (!hold) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ale     = (st == S_T1);
  assign strobe  = (st == S_T2) || (st == S_T3) || (st == S_TW);
  assign active  = ale || strobe || (st == S_T4);
  assign done    = (st == S_T4) && !more;
  assign rd_data = rd_q;
  assign hlda    = (st == S_HOLD);
  assign ctl_oe  = !hlda;

  assign rd_n  = ~(strobe & ~wr_q);
  assign wr_n  = ~(strobe & wr_q);
  assign den_n = ~(strobe | ((st == S_T4) & wr_q));
  assign dtr   = active & wr_q;
  assign mio   = mem_q;

  assign ad_oe  = ale | (active & wr_q);
  assign ad_out = ale ? a_q[DW-1:0] : drive_data;
  assign ah_oe  = active;
  assign ah_out = ale ? a_q[AW-1:DW] : HW'({1'b0, ie_q, seg_q});
  assign bhe_n  = ale ? ~upper_en : 1'b1;
endmodule

// File: rtl/bus_cycle_ctrl_chk.sv
module bus_cycle_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       den_n,
  input logic       hlda,
  input logic       hold,
  input logic       ready,
  input logic       done,
  input logic       ad_oe,
  input logic       ah_oe,
  input logic       ctl_oe,
  input logic [3:0] ah_out,
  input logic       bhe_n
);
  assert_ale_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);
  assert_ale_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n));
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  assert_status_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (ah_oe && !ale) |-> (!ah_out[3] && bhe_n));
  assert_wait_keeps_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (!(rd_n && wr_n) && !ready) |=> !(rd_n && wr_n));
  assert_strobe_den_R4: assert property (@(posedge clk) disable iff (rst)
    !(rd_n && wr_n) |-> !den_n);
  assert_done_idle_strobes_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_n && wr_n));
  assert_float_R9: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!ad_oe && !ah_oe && !ctl_oe));
  assert_grant_after_req_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(hlda) |-> $past(hold));
endmodule

bind bus_cycle_ctrl bus_cycle_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n),
  .hlda(hlda), .hold(hold), .ready(ready), .done(done), .ad_oe(ad_oe),
  .ah_oe(ah_oe), .ctl_oe(ctl_oe), .ah_out(ah_out), .bhe_n(bhe_n)
);

// File: tb/bus_cycle_ctrl_bench.sv
module bus_cycle_ctrl_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_mem = 0, req_word = 0, req_ie = 0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_seg = '0;
  logic ready = 1, hold = 0;
  logic done, hlda, ad_oe, ah_oe, bhe_n, ale, rd_n, wr_n, mio, dtr, den_n, ctl_oe;
  logic [15:0] rd_data, ad_in, ad_out;
  logic [3:0]  ah_out;
  logic [19:0] la = '0;

  int tests = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] mb(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'hA5;
  endfunction

  assign ad_in = {mb(la | 20'h1), mb(la & ~20'h1)};

  bus_cycle_ctrl u_bus_cycle_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_mem(req_mem), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_seg(req_seg), .req_ie(req_ie), .done(done),
    .rd_data(rd_data), .ready(ready), .hold(hold), .hlda(hlda), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .ah_out(ah_out), .ah_oe(ah_oe),
    .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .mio(mio), .dtr(dtr),
    .den_n(den_n), .ctl_oe(ctl_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit w, input bit m, input bit wd, input logic [19:0] a,
                       input logic [15:0] d, input logic [1:0] sg, input bit ie);
    req_write = w; req_mem = m; req_word = wd; req_addr = a;
    req_wdata = d; req_seg = sg; req_ie = ie; req_valid = 1;
  endtask

  task automatic xfer(input bit w, input bit m, input bit wd, input logic [19:0] a,
                      input logic [15:0] d, input logic [1:0] sg, input bit ie,
                      input int nw, input bit hold_mid, input bit pre);
    int part = 0, scnt = 0, wdone = 0, cyc = 0;
    bit fin = 0, endchk = 0, aligned;
    logic [7:0] bv;
    logic [15:0] exp_rd;
    aligned = wd && !a[0];
    exp_rd = wd ? {mb(a + 20'h1), mb(a)} : {8'h00, mb(a)};
    if (!pre) begin
      @(negedge clk);
      issue(w, m, wd, a, d, sg, ie);
    end
    while (!fin && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (ale) begin
        part++; scnt = 0; wdone = 0; endchk = 0;
        la = {ah_out, ad_out};
        check(la == ((part == 1) ? a : a + 20'h1), "R2/R8 address", la,
              (part == 1) ? a : a + 20'h1);
        check(ad_oe && ah_oe && rd_n && wr_n, "R10 strobes in address cycle",
              {rd_n, wr_n}, 2'b11);
        check(mio == m, "R11 memory select", mio, m);
        check(dtr == w, "R4/R5 direction", dtr, w);
        check(bhe_n == !(aligned || la[0]), "R7 upper lane enable", bhe_n,
              !(aligned || la[0]));
      end else if (!(rd_n && wr_n)) begin
        scnt++;
        if (scnt == 1) begin
          check(ah_out == {1'b0, ie, sg} && bhe_n, "R3 status", {bhe_n, ah_out},
                {1'b1, 1'b0, ie, sg});
          check(!den_n, "R4 buffer enable", den_n, 0);
          if (w) begin
            bv = (wd && part == 2) ? d[15:8] : d[7:0];
            check(!wr_n && rd_n && ad_oe, "R5 write strobe", {wr_n, rd_n, ad_oe}, 3'b011);
            if (aligned) check(ad_out == d, "R5 write data", ad_out, d);
            else check((la[0] ? ad_out[15:8] : ad_out[7:0]) == bv, "R7/R8 write lane",
                       ad_out, bv);
          end else begin
            check(!rd_n && wr_n && !ad_oe && !dtr, "R4 read strobe",
                  {rd_n, wr_n, ad_oe, dtr}, 4'b0100);
          end
          if (hold_mid) hold = 1;
        end
        if (scnt >= 2) begin
          if (wdone < nw) begin ready = 0; wdone++; end
          else ready = 1;
        end
      end else if (ah_oe && scnt > 0 && !endchk) begin
        endchk = 1;
        check(scnt == 2 + nw, "R6 strobe length", scnt, 2 + nw);
      end
      if (hold_mid) check(!hlda, "R9 no grant inside transfer", hlda, 0);
      if (done) begin
        fin = 1;
        check(part == ((wd && a[0]) ? 2 : 1), "R8 cycle count", part,
              (wd && a[0]) ? 2 : 1);
        if (!w) check(rd_data == exp_rd, "R4/R7/R8 read data", rd_data, exp_rd);
        req_valid = 0;
      end
    end
    ready = 1;
    if (!fin) check(0, "R4 done missing", 0, 1);
    if (hold_mid) begin
      @(negedge clk);
      check(!hlda, "R9 idle before grant", hlda, 0);
      @(negedge clk);
      check(hlda && !ad_oe && !ah_oe && !ctl_oe, "R9 grant and float",
            {hlda, ad_oe, ah_oe, ctl_oe}, 4'b1000);
      hold = 0;
      @(negedge clk);
      check(!hlda && ctl_oe, "R9 release", hlda, 0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [19:0] addrs [4] = '{20'h01234, 20'h01235, 20'hABCDE, 20'hFFFFF};
    repeat (3) @(negedge clk);
    check(!ale && rd_n && wr_n && den_n && !hlda && !ad_oe && !ah_oe && !done,
          "R1 reset state", {ale, rd_n, wr_n, den_n, hlda, ad_oe, ah_oe, done},
          8'b01110000);
    rst = 0;
    @(negedge clk);
    check(!ale && !done, "R1 idle after reset", {ale, done}, 0);

    for (int ai = 0; ai < 4; ai++)
      for (int wd = 0; wd < 2; wd++)
        for (int w = 0; w < 2; w++)
          for (int nw = 0; nw < 3; nw++)
            xfer(w[0], ai[0] ^ wd[0], wd[0], addrs[ai],
                 16'h1357 + 16'(ai) * 16'h1111 + 16'(nw), 2'((ai + nw) % 4),
                 w[0] ^ nw[0], nw, 0, 0);

    @(negedge clk);
    issue(0, 1, 1, 20'h00F0F, 16'h0, 2'b11, 1);
    hold = 1;
    @(negedge clk);
    check(hlda && !ale, "R9 hold wins over request", {hlda, ale}, 2'b10);
    repeat (2) begin
      @(negedge clk);
      check(hlda && !ad_oe && !ah_oe && !ctl_oe && !ale, "R9 floated while held",
            {hlda, ad_oe, ah_oe, ctl_oe}, 4'b1000);
    end
    hold = 0;
    @(negedge clk);
    check(!hlda && !ale, "R9 idle after release", {hlda, ale}, 0);
    xfer(0, 1, 1, 20'h00F0F, 16'h0, 2'b11, 1, 0, 0, 1);

    xfer(1, 0, 1, 20'h12345, 16'hBEEF, 2'b01, 0, 1, 1, 0);
    xfer(0, 1, 0, 20'h22222, 16'h0, 2'b10, 1, 2, 1, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule